// File: doc/BRIEF.md
# Cascaded Configurable Interrupt Controller

This block gathers 94 interrupt sources into one request line. It is built from three identical 32-input units: one primary unit and two secondary units. Each input of each unit can be set up independently. The set-up chooses level or edge sensitivity, chooses the active polarity, and chooses whether the input is enabled. Edge events are held in latches until software clears them by writing a one to the matching bit. Level sources follow their input and cannot be cleared. The combined request of each secondary unit feeds one reserved input of the primary unit. A secondary source therefore reaches the output only if the primary unit also enables that reserved input.

All external inputs are first brought into the clock domain by a synchroniser, and then edge detection is applied. The primary unit produces the request output. It also gives the index of its highest-numbered enabled pending input, together with a valid flag, so that software can serve the most important input first.

Software reaches the configuration and status through a single-cycle register port. A write takes effect at the clock edge. The read data is a combinational function of the address.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Global source g belongs to unit g/32, bit g%32. Unit 0 is the primary unit: external bits 0..29 arrive on `pri_src`, and bits 30 and 31 are reserved for the cascade. Sources 32..95 arrive on `sec_src[g-32]`. Address bits [4:3] select the unit (0 primary, 1 first secondary, 2 second secondary). Address bits [2:0] select the register: 0 enable, 1 polarity, 2 type, 3 raw status, 4 masked status. Any other unit or register code reads as zero.
- R2: An enable bit at 1 passes its source and an enable bit at 0 blocks it. Every enable bit is 0 after reset.
- R3: A polarity bit at 1 selects active-high level or rising edge. A polarity bit at 0 selects active-low level or falling edge. Every polarity bit is 1 after reset.
- R4: A type bit at 1 selects edge sensitivity and a type bit at 0 selects level sensitivity. Every type bit is 0 after reset.
- R5: For an edge-type source, a qualifying edge sets the raw status bit, and the bit stays set after the input returns. Writing 1 to the raw status register clears the bit. Writing 0 leaves the bit unchanged. A new edge in the same cycle as the clear takes priority over the clear.
- R6: For a level-type source, the raw status bit equals the synchronised input after the polarity is applied. Writing 1 to clear it has no effect.
- R7: The masked status register equals the raw status ANDed with the enable register.
- R8: The OR of the first secondary unit's masked status drives primary bit 30. The OR of the second secondary unit's masked status drives primary bit 31. These two inputs bypass the synchroniser. A secondary source reaches `irq_out` only when the matching primary bit is enabled.
- R9: `irq_out` is the OR of the primary unit's masked status.
- R10: `irq_idx` gives the highest-numbered set bit of the primary unit's masked status. `irq_idx_valid` is 1 exactly when any such bit is set.
- R11: External inputs pass through a two-flop synchroniser. A level change driven between clock edges shows in raw status after the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_src | input | 30 | External sources of the primary unit (global 0..29) |
| sec_src | input | 64 | External sources of both secondary units (global 32..95) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Unit select [4:3], register select [2:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| irq_out | output | 1 | Combined interrupt request |
| irq_idx | output | 5 | Highest pending enabled primary bit |
| irq_idx_valid | output | 1 | irq_idx is meaningful |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Edge latches that must survive a write of zero.** A design that treats the raw-status write as a plain store would lose pending edges.
- **Level sources that must ignore a clear.** A shared clear path would drop a still-active level request.
- **The cascade gate.** A secondary request must stay invisible while primary bit 30 or 31 is disabled. A design that ORs the secondary units straight into the output would raise `irq_out` too early.
- **Exact three-edge synchroniser latency.** A missing or extra flop shows up as a one-cycle shift.
- **Falling-edge and active-low set-ups under random configuration.** An inverted polarity sense would latch on the wrong transition.
- **Priority between several pending primary bits.** An encoder that favours low bits would report the wrong index.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;
   localparam int NUM_UNITS = 3;
   localparam int ADDR_W    = 5;

   typedef enum logic [2:0] {
      RG_ENABLE = 3'd0,
      RG_POLAR  = 3'd1,
      RG_KIND   = 3'd2,
      RG_RAW    = 3'd3,
      RG_MASKED = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      end else begin
         pipe[0] <= din;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
   parameter int           N         = 32,
   parameter logic [N-1:0] POL_RESET = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_in,
   input  logic         wr_enable,
   input  logic         wr_polar,
   input  logic         wr_kind,
   input  logic         wr_clear,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] enable_q,
   output logic [N-1:0] polar_q,
   output logic [N-1:0] kind_q,
   output logic [N-1:0] raw_q,
   output logic [N-1:0] masked,
   output logic         req
);
   logic [N-1:0] prev_q;
   logic [N-1:0] rise, fall, event_hit, active, clr_bits, raw_nxt;

   always_comb begin
      rise      = lvl_in & ~prev_q;
      fall      = ~lvl_in & prev_q;
      event_hit = (polar_q & rise) | (~polar_q & fall);
      active    = ~(lvl_in ^ polar_q);
      clr_bits  = wr_clear ? wdata : '0;
      raw_nxt   = (kind_q & ((raw_q & ~clr_bits) | event_hit)) | (~kind_q & active);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         polar_q  <= POL_RESET;
         kind_q   <= '0;
         raw_q    <= '0;
         prev_q   <= '0;
      end else begin
         if (wr_enable) enable_q <= wdata;
         if (wr_polar)  polar_q  <= wdata;
         if (wr_kind)   kind_q   <= wdata;
         raw_q  <= raw_nxt;
         prev_q <= lvl_in;
      end
   end

   assign masked = raw_q & enable_q;
   assign req    = |masked;

   // R5
   edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~$past(raw_q) & $past(kind_q) & ~($past(lvl_in) ^ $past(prev_q))) == '0));

   // R5
   zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clear |=> (($past(raw_q & kind_q & ~wdata) & ~raw_q) == '0));
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int N   = 32,
   parameter int IDX = $clog2(N)
) (
   input  logic [N-1:0]   vec,
   output logic [IDX-1:0] idx,
   output logic           valid
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) idx = IDX'(i);
      end
      valid = |vec;
   end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
   import irq_casc_pkg::*;
#(
   parameter int                N_SRC       = 32,
   parameter int                SYNC_STAGES = 2,
   parameter logic [N_SRC-1:0]  POL_RESET   = '1,
   localparam int               PRI_EXT     = N_SRC - 2,
   localparam int               SEC_EXT     = 2 * N_SRC,
   localparam int               IDX_W       = $clog2(N_SRC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PRI_EXT-1:0] pri_src,
   input  logic [SEC_EXT-1:0] sec_src,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [N_SRC-1:0]   reg_wdata,
   output logic [N_SRC-1:0]   reg_rdata,
   output logic               irq_out,
   output logic [IDX_W-1:0]   irq_idx,
   output logic               irq_idx_valid
);
   localparam int SYNC_W = PRI_EXT + SEC_EXT;

   if (N_SRC < 3 || N_SRC > 32) begin : g_bad_width
      $error("N_SRC must lie in 3..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_W-1:0] src_s;
   logic [N_SRC-1:0]  u_in     [NUM_UNITS];
   logic [N_SRC-1:0]  u_enable [NUM_UNITS];
   logic [N_SRC-1:0]  u_polar  [NUM_UNITS];
   logic [N_SRC-1:0]  u_kind   [NUM_UNITS];
   logic [N_SRC-1:0]  u_raw    [NUM_UNITS];
   logic [N_SRC-1:0]  u_masked [NUM_UNITS];
   logic              u_req    [NUM_UNITS];

   irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({sec_src, pri_src}),
      .dout (src_s)
   );

   always_comb begin
      u_in[0] = {u_req[2], u_req[1], src_s[PRI_EXT-1:0]};
      u_in[1] = src_s[PRI_EXT +: N_SRC];
      u_in[2] = src_s[PRI_EXT + N_SRC +: N_SRC];
   end

   for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
      logic hit;
      assign hit = reg_we && (reg_addr[4:3] == 2'(k));

      irq_unit #(.N(N_SRC), .POL_RESET(POL_RESET)) u_unit (
         .clk      (clk),
         .rst_n    (rst_n),
         .lvl_in   (u_in[k]),
         .wr_enable(hit && reg_addr[2:0] == RG_ENABLE),
         .wr_polar (hit && reg_addr[2:0] == RG_POLAR),
         .wr_kind  (hit && reg_addr[2:0] == RG_KIND),
         .wr_clear (hit && reg_addr[2:0] == RG_RAW),
         .wdata    (reg_wdata),
         .enable_q (u_enable[k]),
         .polar_q  (u_polar[k]),
         .kind_q   (u_kind[k]),
         .raw_q    (u_raw[k]),
         .masked   (u_masked[k]),
         .req      (u_req[k])
      );
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[4:3] < 2'(NUM_UNITS)) begin
         case (reg_addr[2:0])
            RG_ENABLE: reg_rdata = u_enable[reg_addr[4:3]];
            RG_POLAR:  reg_rdata = u_polar[reg_addr[4:3]];
            RG_KIND:   reg_rdata = u_kind[reg_addr[4:3]];
            RG_RAW:    reg_rdata = u_raw[reg_addr[4:3]];
            RG_MASKED: reg_rdata = u_masked[reg_addr[4:3]];
            default:   reg_rdata = '0;
         endcase
      end
   end

   irq_prio #(.N(N_SRC)) u_prio (
      .vec  (u_masked[0]),
      .idx  (irq_idx),
      .valid(irq_idx_valid)
   );

   assign irq_out = u_req[0];

   // R9
   req_valid_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == irq_idx_valid);

   // R10
   idx_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_idx_valid |-> ((u_masked[0] >> irq_idx) == N_SRC'(1)));
endmodule

// File: tb/sim_cascade_irq_ctrl.sv
module sim_cascade_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] pri_src = '0;
   logic [63:0] sec_src = '0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_out;
   logic [4:0]  irq_idx;
   logic        irq_idx_valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] m_en [3];
   logic [31:0] m_pol [3];
   logic [31:0] m_typ [3];
   logic [31:0] m_lat [3];

   always #2.5 clk = ~clk;

   cascade_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .pri_src(pri_src), .sec_src(sec_src),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_idx(irq_idx),
      .irq_idx_valid(irq_idx_valid)
   );

   function automatic logic [31:0] raw_of(logic [31:0] in, logic [31:0] pol,
                                          logic [31:0] typ, logic [31:0] lat);
      return (typ & lat) | (~typ & ~(in ^ pol));
   endfunction

   function automatic logic [31:0] unit_in(int u);
      logic r1, r2;
      if (u == 1) return sec_src[31:0];
      if (u == 2) return sec_src[63:32];
      r1 = |(raw_of(sec_src[31:0], m_pol[1], m_typ[1], m_lat[1]) & m_en[1]);
      r2 = |(raw_of(sec_src[63:32], m_pol[2], m_typ[2], m_lat[2]) & m_en[2]);
      return {r2, r1, pri_src};
   endfunction

   function automatic logic [31:0] exp_raw(int u);
      return raw_of(unit_in(u), m_pol[u], m_typ[u], m_lat[u]);
   endfunction

   function automatic logic [31:0] exp_stat(int u);
      return exp_raw(u) & m_en[u];
   endfunction

   function automatic logic [4:0] exp_idx(logic [31:0] s);
      logic [4:0] r = '0;
      for (int i = 0; i < 32; i++) if (s[i]) r = 5'(i);
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int u, int r, logic [31:0] d);
      logic [31:0] lvl, newly;
      @(negedge clk);
      lvl = ~(unit_in(u) ^ m_pol[u]);
      reg_we = 1'b1; reg_addr = {2'(u), 3'(r)}; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (r)
         0: m_en[u] = d;
         1: m_pol[u] = d;
         2: begin
            newly = d & ~m_typ[u];
            m_lat[u] = (m_lat[u] & ~newly) | (lvl & newly);
            m_typ[u] = d;
         end
         3: m_lat[u] = m_lat[u] & ~d;
         default: ;
      endcase
      idle(6);
   endtask

   task automatic drive(logic [29:0] np, logic [63:0] ns);
      logic [31:0] o, n;
      for (int u = 0; u < 3; u++) begin
         o = (u == 0) ? {2'b00, pri_src} : (u == 1 ? sec_src[31:0] : sec_src[63:32]);
         n = (u == 0) ? {2'b00, np} : (u == 1 ? ns[31:0] : ns[63:32]);
         for (int b = 0; b < 32; b++) begin
            if (!(u == 0 && b >= 30) && m_typ[u][b] && (o[b] != n[b]) && (n[b] == m_pol[u][b]))
               m_lat[u][b] = 1'b1;
         end
      end
      @(negedge clk);
      pri_src = np; sec_src = ns;
      idle(6);
   endtask

   task automatic rd(int u, int r, output logic [31:0] v);
      @(negedge clk);
      reg_addr = {2'(u), 3'(r)};
      #1 v = reg_rdata;
   endtask

   task automatic check_all();
      logic [31:0] v;
      for (int u = 0; u < 3; u++) begin
         rd(u, 0, v); chk("R2 enable", v, m_en[u]);
         rd(u, 1, v); chk("R3 polarity", v, m_pol[u]);
         rd(u, 2, v); chk("R4 type", v, m_typ[u]);
         rd(u, 3, v); chk("R5/R6 raw", v, exp_raw(u));
         rd(u, 4, v); chk("R7 masked", v, exp_stat(u));
      end
      chk("R9 irq_out", 32'(irq_out), 32'(|exp_stat(0)));
      chk("R10 valid", 32'(irq_idx_valid), 32'(|exp_stat(0)));
      if (|exp_stat(0)) chk("R10 index", 32'(irq_idx), 32'(exp_idx(exp_stat(0))));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] cfg;
      for (int u = 0; u < 3; u++) begin
         m_en[u] = '0; m_pol[u] = '1; m_typ[u] = '0; m_lat[u] = '0;
      end
      idle(4);
      rst_n = 1'b1;
      idle(3);
      check_all();

      // R1 and R8: first secondary source 37 (unit 1 bit 5) through the cascade gate
      wr(1, 0, 32'h0000_0020);
      drive(pri_src, 64'h20);
      rd(1, 3, v); chk("R1 unit1 bit5 raw", v, 32'h20);
      chk("R8 gate closed", 32'(irq_out), 32'h0);
      wr(0, 0, 32'h4000_0000);
      chk("R8 gate open irq", 32'(irq_out), 32'h1);
      chk("R8 gate open index", 32'(irq_idx), 32'd30);
      check_all();

      // R5: edge latch on second secondary, unit 2 bit 3
      wr(2, 2, 32'h8);
      wr(2, 3, 32'h8);
      wr(2, 0, 32'h8);
      wr(0, 0, 32'hC000_0000);
      drive(pri_src, sec_src | 64'h8_0000_0000);
      drive(pri_src, sec_src & ~64'h8_0000_0000);
      rd(2, 3, v); chk("R5 latched after input fell", v & 32'h8, 32'h8);
      chk("R8 second cascade index", 32'(irq_idx), 32'd31);
      wr(2, 3, 32'h0);
      rd(2, 3, v); chk("R5 zero write keeps", v & 32'h8, 32'h8);
      wr(2, 3, 32'h8);
      rd(2, 3, v); chk("R5 one write clears", v & 32'h8, 32'h0);
      // R3: falling edge
      wr(2, 1, ~32'h8);
      drive(pri_src, sec_src | 64'h8_0000_0000);
      rd(2, 3, v); chk("R3 rising ignored when falling", v & 32'h8, 32'h0);
      drive(pri_src, sec_src & ~64'h8_0000_0000);
      rd(2, 3, v); chk("R3 falling edge latched", v & 32'h8, 32'h8);
      check_all();

      // R6: active-low level cannot be cleared
      wr(0, 1, ~32'h10);
      wr(0, 0, 32'hC000_0010);
      rd(0, 3, v); chk("R6 low level active", v & 32'h10, 32'h10);
      wr(0, 3, 32'h10);
      rd(0, 3, v); chk("R6 clear ignored on level", v & 32'h10, 32'h10);
      drive(pri_src | 30'h10, sec_src);
      rd(0, 3, v); chk("R6 level follows input", v & 32'h10, 32'h0);

      // R10: several primary bits pending
      wr(0, 1, '1);
      wr(0, 0, 32'h0000_0F03);
      drive(30'h0000_0A03, sec_src);
      chk("R10 highest index", 32'(irq_idx), 32'd11);
      check_all();

      // R11: exact synchroniser latency on primary bit 7
      wr(0, 0, 32'h80);
      @(negedge clk);
      reg_addr = {2'd0, 3'd3};
      pri_src = pri_src | 30'h80;
      @(negedge clk); #1 chk("R11 after one edge", reg_rdata & 32'h80, 32'h0);
      @(negedge clk); #1 chk("R11 after two edges", reg_rdata & 32'h80, 32'h0);
      @(negedge clk); #1 chk("R11 after three edges", reg_rdata & 32'h80, 32'h80);
      idle(4);

      // R1: unused address codes read zero
      rd(3, 0, v); chk("R1 unit code 3", v, 32'h0);
      rd(0, 5, v); chk("R1 register code 5", v, 32'h0);

      // random mix
      void'($urandom(32'd1234));
      for (int it = 0; it < 60; it++) begin
         int u, r;
         u = $urandom_range(2, 0);
         r = $urandom_range(3, 0);
         cfg = $urandom;
         if (u == 0 && r == 1) cfg[31:30] = 2'b11;
         if (u == 0 && r == 2) cfg[31:30] = 2'b00;
         wr(u, r, cfg);
         drive(30'($urandom), {32'($urandom), 32'($urandom)});
         check_all();
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule